// File: doc/BRIEF.md
# SHA-2 Round Sum Compressor

This block forms the two new working-variable values that a SHA-2 compression round writes back: the next `a` and the next `e`. It receives eight 32-bit operands: the old `h` and `d`, the round constant, the schedule word, and the four logic-function results Σ1(e), Ch, Σ0(a) and Maj. From these it returns `next_a = T1 + T2` and `next_e = d + T1`. Here `T1 = h + Σ1 + Ch + K + W` and `T2 = Σ0 + Maj`. Every sum wraps modulo 2^W.

The logic is purely combinational. The operands are reduced by a cascade of 3:2 carry-save stages, and each output then passes through one carry-propagate adder. The first stage joins `h`, the constant and the schedule word, because these come straight from registers or a ROM. The logic-function results join at later stages, because the combinational logic ahead of this block makes them arrive later. `next_e` takes the carry-save form of T1, adds `d` in its own stage, and resolves the result in its own adder. The Σ/Ch/Maj logic and the state registers are outside this block.

Top module: `round_sum_csa`

## Requirements
- R1: `next_a` equals h + Σ1 + Ch + K + W + Σ0 + Maj, truncated to the low W bits, for every input combination.
- R2: `next_e` equals d + h + Σ1 + Ch + K + W, truncated to the low W bits, for every input combination.
- R3: Carries out of the top bit are dropped. With every operand all-ones, `next_a` is 2^W − 7 (0xFFFFFFF9 for W=32) and `next_e` is 2^W − 6 (0xFFFFFFFA).
- R4: With every operand zero, both outputs are zero.
- R5: `next_e` does not depend on Σ0 or Maj. Changing only those two inputs leaves `next_e` unchanged.
- R6: `next_a` does not depend on `d`. Changing only `d` leaves `next_a` unchanged.
- R7: A carry that travels the full width resolves correctly. With h = 2^W − 1, K = 1 and all other operands zero, `next_a` and `next_e` are both 0. With only bit W−1 set in both h and W, both outputs are 0.
- R8: The outputs are combinational. They reflect a change at the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| h_in | input | W | Old `h` working variable |
| d_in | input | W | Old `d` working variable |
| ksum_in | input | W | Round constant K for this round |
| wsched_in | input | W | Message schedule word for this round |
| sig1_in | input | W | Σ1(e) result |
| choose_in | input | W | Ch(e,f,g) result |
| sig0_in | input | W | Σ0(a) result |
| major_in | input | W | Maj(a,b,c) result |
| next_a | output | W | T1 + T2 mod 2^W |
| next_e | output | W | d + T1 mod 2^W |

## Verification
The hardest case to reach from the ports is a carry that must travel through the carry-save vectors and then across the whole final adder. Random operands almost never produce it. Directed vectors supply it: an all-ones `h` plus one, matching top bits whose carry falls off the end, and all operands at all-ones, which fills every carry vector at every stage. The independence of each output from the other output's private operands is checked by changing only those operands and comparing against the value held from the previous vector.

// File: rtl/round_sum_csa.sv
module round_sum_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] h_in,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] ksum_in,
  input  logic [W-1:0] wsched_in,
  input  logic [W-1:0] sig1_in,
  input  logic [W-1:0] choose_in,
  input  logic [W-1:0] sig0_in,
  input  logic [W-1:0] major_in,
  output logic [W-1:0] next_a,
  output logic [W-1:0] next_e
);

  localparam int MSB = W - 1;

  function automatic logic [W-1:0] csa_sum(input logic [W-1:0] x, y, z);
    return x ^ y ^ z;
  endfunction

  function automatic logic [W-1:0] csa_cry(input logic [W-1:0] x, y, z);
    logic [W-1:0] m;
    m = (x & y) | (x & z) | (y & z);
    return {m[MSB-1:0], 1'b0};
  endfunction

  // stage 1: early operands
  logic [W-1:0] l1_s, l1_c;
  assign l1_s = csa_sum(h_in, ksum_in, wsched_in);
  assign l1_c = csa_cry(h_in, ksum_in, wsched_in);

  // stage 2/3: late logic-function results
  logic [W-1:0] l2_s, l2_c, t1_s, t1_c;
  assign l2_s = csa_sum(l1_s, l1_c, sig1_in);
  assign l2_c = csa_cry(l1_s, l1_c, sig1_in);
  assign t1_s = csa_sum(l2_s, l2_c, choose_in);
  assign t1_c = csa_cry(l2_s, l2_c, choose_in);

  // e path
  logic [W-1:0] e_s, e_c;
  assign e_s = csa_sum(t1_s, t1_c, d_in);
  assign e_c = csa_cry(t1_s, t1_c, d_in);

  // a path
  logic [W-1:0] a4_s, a4_c, a5_s, a5_c;
  assign a4_s = csa_sum(t1_s, t1_c, sig0_in);
  assign a4_c = csa_cry(t1_s, t1_c, sig0_in);
  assign a5_s = csa_sum(a4_s, a4_c, major_in);
  assign a5_c = csa_cry(a4_s, a4_c, major_in);

  // carry-propagate adders, carry out dropped
  assign next_a = a5_s + a5_c;
  assign next_e = e_s + e_c;

endmodule

// File: rtl/round_sum_csa_chk.sv
module round_sum_csa_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] h_in,
  input logic [W-1:0] d_in,
  input logic [W-1:0] ksum_in,
  input logic [W-1:0] wsched_in,
  input logic [W-1:0] sig1_in,
  input logic [W-1:0] choose_in,
  input logic [W-1:0] sig0_in,
  input logic [W-1:0] major_in,
  input logic [W-1:0] next_a,
  input logic [W-1:0] next_e,
  input logic [W-1:0] l1_s,
  input logic [W-1:0] l1_c,
  input logic [W-1:0] t1_s,
  input logic [W-1:0] t1_c
);

  logic [W-1:0] ref_t1, ref_a, ref_e;
  logic         known;
  always_comb begin
    ref_t1 = h_in + ksum_in + wsched_in + sig1_in + choose_in;
    ref_a  = ref_t1 + sig0_in + major_in;
    ref_e  = ref_t1 + d_in;
    known  = !$isunknown({h_in, d_in, ksum_in, wsched_in, sig1_in,
                          choose_in, sig0_in, major_in});
  end

  always_comb begin
    if (known) begin
      p_a_sum_r1: assert (next_a == ref_a)
        else $error("R1 next_a mismatch");
      p_e_sum_r2: assert (next_e == ref_e)
        else $error("R2 next_e mismatch");
      p_stage1_keeps_sum_r1: assert (W'(l1_s + l1_c) == W'(h_in + ksum_in + wsched_in))
        else $error("R1 first-stage carry-save pair lost value");
      p_t1_pair_r2: assert (W'(t1_s + t1_c) == ref_t1)
        else $error("R2 T1 carry-save pair lost value");
      p_a_minus_e_r5: assert (W'(next_a - next_e) == W'(sig0_in + major_in - d_in))
        else $error("R5/R6 output difference wrong");
    end
  end

endmodule

bind round_sum_csa round_sum_csa_chk #(.W(W)) u_chk (
  .h_in(h_in), .d_in(d_in), .ksum_in(ksum_in), .wsched_in(wsched_in),
  .sig1_in(sig1_in), .choose_in(choose_in), .sig0_in(sig0_in),
  .major_in(major_in), .next_a(next_a), .next_e(next_e),
  .l1_s(l1_s), .l1_c(l1_c), .t1_s(t1_s), .t1_c(t1_c)
);

// File: tb/round_sum_csa_tb.sv
module round_sum_csa_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] h, d, k, w, s1, ch, s0, mj;
  logic [W-1:0] na, ne;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  round_sum_csa #(.W(W)) u_dut (
    .h_in(h), .d_in(d), .ksum_in(k), .wsched_in(w),
    .sig1_in(s1), .choose_in(ch), .sig0_in(s0), .major_in(mj),
    .next_a(na), .next_e(ne)
  );

  task automatic check(input string req, input logic [W-1:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] vh, vd, vk, vw, vs1, vch, vs0, vmj);
    @(posedge clk);
    h = vh; d = vd; k = vk; w = vw; s1 = vs1; ch = vch; s0 = vs0; mj = vmj;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_a();
    logic [63:0] t;
    t = 64'(h) + 64'(k) + 64'(w) + 64'(s1) + 64'(ch) + 64'(s0) + 64'(mj);
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] exp_e();
    logic [63:0] t;
    t = 64'(h) + 64'(k) + 64'(w) + 64'(s1) + 64'(ch) + 64'(d);
    return t[W-1:0];
  endfunction

  task automatic t_zero_r4();
    drive('0, '0, '0, '0, '0, '0, '0, '0);
    check("R4 next_a", na, '0);
    check("R4 next_e", ne, '0);
  endtask

  task automatic t_ones_r3();
    drive('1, '1, '1, '1, '1, '1, '1, '1);
    check("R3 next_a", na, 32'hFFFF_FFF9);
    check("R3 next_e", ne, 32'hFFFF_FFFA);
  endtask

  task automatic t_ripple_r7();
    drive(32'hFFFF_FFFF, '0, 32'h1, '0, '0, '0, '0, '0);
    check("R7 next_a full ripple", na, '0);
    check("R7 next_e full ripple", ne, '0);
    drive(32'h8000_0000, '0, '0, 32'h8000_0000, '0, '0, '0, '0);
    check("R7 next_a top carry", na, '0);
    check("R7 next_e top carry", ne, '0);
  endtask

  task automatic t_known_r1_r2();
    drive(32'h5BE0CD19, 32'hA54FF53A, 32'h428A2F98, 32'h61626380,
          32'h3587272B, 32'h1F85C98C, 32'hCE20B47E, 32'h3A6FE667);
    check("R1 next_a known", na, exp_a());
    check("R2 next_e known", ne, exp_e());
  endtask

  task automatic t_random_r1_r2();
    for (int i = 0; i < 200; i++) begin
      drive($urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom);
      check("R1 next_a random", na, exp_a());
      check("R2 next_e random", ne, exp_e());
    end
  endtask

  task automatic t_indep_r5_r6();
    logic [W-1:0] held;
    drive(32'h1234_5678, 32'h0BAD_F00D, 32'h7, 32'h99, 32'hCAFE, 32'h55, 32'h10, 32'h20);
    held = ne;
    drive(h, d, k, w, s1, ch, 32'hFFFF_0000, 32'h0F0F_0F0F);
    check("R5 next_e unchanged by sig0/maj", ne, held);
    held = na;
    drive(h, 32'hDEAD_BEEF, k, w, s1, ch, s0, mj);
    check("R6 next_a unchanged by d", na, held);
  endtask

  task automatic t_comb_r8();
    drive('0, '0, '0, '0, '0, '0, '0, '0);
    @(posedge clk);
    #3;
    s0 = 32'h0000_0005;
    d  = 32'h0000_0009;
    #2;
    check("R8 next_a without clock", na, 32'h5);
    check("R8 next_e without clock", ne, 32'h9);
  endtask

  initial begin
    h = '0; d = '0; k = '0; w = '0; s1 = '0; ch = '0; s0 = '0; mj = '0;
    repeat (2) @(posedge clk);
    t_zero_r4();
    t_ones_r3();
    t_ripple_r7();
    t_known_r1_r2();
    t_indep_r5_r6();
    t_comb_r8();
    t_random_r1_r2();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule